// File: doc/BRIEF.md
# Reader Response Window Timer

This block is a countdown timer for the front end of a contactless card reader. It measures how long the reader waits for a card to answer. A power-of-two prescaler divides the input clock into ticks, and an 8-bit down counter counts those ticks from a programmed reload value. When the count runs out, the timer raises a sticky interrupt request.

Software programs the timer through a small write port with four addresses: clock setup, reload value, trigger enables and a command register. Software can start the timer directly. It can also enable single-cycle framing pulses from the transmitter (begin and end of a frame) to start it and pulses from the receiver (begin and end of a frame) to stop it. This lets the window open when a request leaves the antenna and close when an answer arrives. The live count and a running flag are visible on the outputs.

Register layout:
- Address 0 (clock setup): bits [3:0] hold the prescale exponent N; bit 7 is the auto-restart flag.
- Address 1: the reload value.
- Address 2 (trigger enables):
  - bit 0: start on transmit begin
  - bit 1 (0x02): start on transmit end
  - bit 2: stop on receive begin
  - bit 3: stop on receive end
- Address 3 (command; a write acts only in its own cycle):
  - bit 0: clear the interrupt request
  - bit 1: start
  - bit 2 (0x04): stop

Top module: `rdr_timeout_timer`

## Requirements
- R1: After reset, `running_o`, `count_o` and `irq_o` are 0, the exponent is 0, auto-restart is off, the reload value is 0 and all trigger enables are off.
- R2: One tick takes 2^N clock cycles, where N is the exponent captured at start. For example, N=7 gives 128 cycles and N=15 gives 32768 cycles. Every start clears the prescaler, so the first tick takes a full period.
- R3: A start loads `count_o` with the reload value R. Each tick decrements the count. The timer expires on the tick that would take the count from 1 (or from 0) downward. So a reload of R≥1 expires after R ticks, and a reload of 0 expires on the first tick.
- R4: On expiry with auto-restart off, the timer halts with `count_o`=0. With auto-restart on, it reloads R and keeps running.
- R5: Writing command bit 2 (0x04) stops the timer at the next edge and holds `count_o` at its value.
- R6: A transmit-begin pulse starts the timer only when enable bit 0 is set. A transmit-end pulse starts it only when enable bit 1 is set. A pulse whose enable bit is clear has no effect.
- R7: A receive-begin pulse stops the timer only when enable bit 2 is set. A receive-end pulse stops it only when enable bit 3 is set. A pulse whose enable bit is clear has no effect.
- R8: When a start and a stop occur in the same cycle, from any mix of command and trigger sources, the stop wins and the timer ends up halted.
- R9: Writing the reload value while the timer runs leaves `count_o` unchanged. The new value is used only at the next start or auto-reload.
- R10: Expiry sets `irq_o`, which stays set until command bit 0 is written. If an expiry and a clear fall in the same cycle, the expiry wins.
- R11: A start while the timer is already running reloads the count and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| tx_begin_i | input | 1 | Transmit frame begin pulse |
| tx_end_i | input | 1 | Transmit frame end pulse |
| rx_begin_i | input | 1 | Receive frame begin pulse |
| rx_end_i | input | 1 | Receive frame end pulse |
| count_o | output | 8 | Current count |
| running_o | output | 1 | Timer is counting |
| irq_o | output | 1 | Sticky expiry interrupt request |

## Verification
The hardest cases to reach from the ports depend on exact timing:
- an interrupt clear that lands in the same cycle as an auto-restart expiry;
- a reload write that lands in the middle of a run;
- a start pulse and a stop pulse that arrive on the same edge.

The stimulus counts cycles from a known start so that each of these writes or pulses lands on the intended edge. A behavioural model, stepped every clock, confirms the timing independently. The largest exponent is also run to its expiry edge to confirm the full 2^15-cycle tick.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam logic [1:0] ADDR_CLK = 2'd0;
  localparam logic [1:0] ADDR_RLD = 2'd1;
  localparam logic [1:0] ADDR_TRG = 2'd2;
  localparam logic [1:0] ADDR_CMD = 2'd3;

  localparam int CMD_CLR_BIT   = 0;
  localparam int CMD_START_BIT = 1;
  localparam int CMD_STOP_BIT  = 2;
  localparam int AUTO_BIT      = 7;

  typedef struct packed {
    logic stop_rx_end;
    logic stop_rx_beg;
    logic start_tx_end;
    logic start_tx_beg;
  } trig_en_t;
endpackage

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic              auto_o,
  output logic [CNT_W-1:0]  reload_o,
  output trig_en_t          trig_o,
  output logic              cmd_start_o,
  output logic              cmd_stop_o,
  output logic              cmd_clr_o
);
  logic cmd_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_o    <= '0;
      auto_o   <= 1'b0;
      reload_o <= '0;
      trig_o   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CLK: begin
          exp_o  <= wdata_i[EXP_W-1:0];
          auto_o <= wdata_i[AUTO_BIT];
        end
        ADDR_RLD: reload_o <= CNT_W'(wdata_i);
        ADDR_TRG: trig_o   <= trig_en_t'(wdata_i[3:0]);
        default: ;
      endcase
    end
  end

  // command bits act only in the cycle of the write
  assign cmd_we      = we_i && (addr_i == ADDR_CMD);
  assign cmd_start_o = cmd_we && wdata_i[CMD_START_BIT];
  assign cmd_stop_o  = cmd_we && wdata_i[CMD_STOP_BIT];
  assign cmd_clr_o   = cmd_we && wdata_i[CMD_CLR_BIT];
endmodule

// File: rtl/rtt_trigger.sv
module rtt_trigger
  import rtt_pkg::*;
(
  input  trig_en_t en_i,
  input  logic     cmd_start_i,
  input  logic     cmd_stop_i,
  input  logic     tx_begin_i,
  input  logic     tx_end_i,
  input  logic     rx_begin_i,
  input  logic     rx_end_i,
  output logic     start_o,
  output logic     stop_o
);
  logic stop_any;

  assign stop_any = cmd_stop_i
                  | (en_i.stop_rx_beg & rx_begin_i)
                  | (en_i.stop_rx_end & rx_end_i);
  assign stop_o  = stop_any;
  // stop has priority over any start source
  assign start_o = !stop_any & (cmd_start_i
                  | (en_i.start_tx_beg & tx_begin_i)
                  | (en_i.start_tx_end & tx_end_i));
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [EXP_W-1:0] exp_q;
  logic [PRE_W-1:0] limit;

  // 2^N - 1 from the exponent captured at start
  assign limit  = {PRE_W{1'b1}} >> (PRE_W - int'(exp_q));
  assign tick_o = run_i && !start_i && !stop_i && (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      exp_q <= '0;
    end else if (start_i) begin
      pre_q <= '0;
      exp_q <= exp_i;
    end else if (run_i && !stop_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end

  a_r2_full_first_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i && (exp_i != '0) |=> !tick_o);
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o,
  output logic             irq_o
);
  assign expire_o = tick_i && (count_o <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      running_o <= 1'b0;
    end else if (stop_i) begin
      running_o <= 1'b0;
    end else if (start_i) begin
      running_o <= 1'b1;
      count_o   <= reload_i;
    end else if (tick_i) begin
      if (expire_o) begin
        if (auto_i) count_o <= reload_i;
        else begin
          count_o   <= '0;
          running_o <= 1'b0;
        end
      end else begin
        count_o <= count_o - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (expire_o) irq_o <= 1'b1;
    else if (clr_i)    irq_o <= 1'b0;
  end

  a_r3_expire_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> irq_o);
  a_r4_halt_without_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !auto_i |=> !running_o && (count_o == '0));
  a_r4_reload_with_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && auto_i |=> running_o && (count_o == $past(reload_i)));
  a_r5_stop_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o && $stable(count_o));
  a_r11_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> running_o && (count_o == $past(reload_i)));
  a_r9_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !start_i && !stop_i |=> $stable(count_o));
  a_r8_no_start_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && stop_i));
endmodule

// File: rtl/rdr_timeout_timer.sv
module rdr_timeout_timer
  import rtt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              tx_begin_i,
  input  logic              tx_end_i,
  input  logic              rx_begin_i,
  input  logic              rx_end_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o,
  output logic              irq_o
);
  logic [EXP_W-1:0] exp_cfg;
  logic             auto_cfg;
  logic [CNT_W-1:0] reload_cfg;
  trig_en_t         trig_cfg;
  logic             cmd_start, cmd_stop, cmd_clr;
  logic             start_ev, stop_ev, tick, expire;

  rtt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EXP_W(EXP_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .exp_o(exp_cfg), .auto_o(auto_cfg), .reload_o(reload_cfg), .trig_o(trig_cfg),
    .cmd_start_o(cmd_start), .cmd_stop_o(cmd_stop), .cmd_clr_o(cmd_clr)
  );

  rtt_trigger u_trig (
    .en_i(trig_cfg), .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
    .tx_begin_i, .tx_end_i, .rx_begin_i, .rx_end_i,
    .start_o(start_ev), .stop_o(stop_ev)
  );

  rtt_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk_i, .rst_ni, .start_i(start_ev), .stop_i(stop_ev),
    .run_i(running_o), .exp_i(exp_cfg), .tick_o(tick)
  );

  rtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i(start_ev), .stop_i(stop_ev), .tick_i(tick),
    .clr_i(cmd_clr), .auto_i(auto_cfg), .reload_i(reload_cfg),
    .count_o, .running_o, .expire_o(expire), .irq_o
  );

  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !cmd_clr |=> irq_o);
  a_r7_stop_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_cfg.stop_rx_end && rx_end_i |=> !running_o);
endmodule

// File: tb/rdr_timeout_timer_bench.sv
module rdr_timeout_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       txb = 1'b0, txe = 1'b0, rxb = 1'b0, rxe = 1'b0;
  logic [7:0] count;
  logic       running, irq;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int m_run, m_cnt, m_pre, m_exp, m_irq, m_cfg_exp, m_auto, m_reload, m_trg;

  always #5 clk = ~clk;

  rdr_timeout_timer u_rdr_timeout_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .tx_begin_i(txb), .tx_end_i(txe), .rx_begin_i(rxb), .rx_end_i(rxe),
    .count_o(count), .running_o(running), .irq_o(irq)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_pre = 0; m_exp = 0; m_irq = 0;
      m_cfg_exp = 0; m_auto = 0; m_reload = 0; m_trg = 0;
    end else begin
      bit st, sp, cl, ex;
      st = (we && addr == 3 && wdata[1]) || (m_trg[0] && txb) || (m_trg[1] && txe);
      sp = (we && addr == 3 && wdata[2]) || (m_trg[2] && rxb) || (m_trg[3] && rxe);
      cl = we && addr == 3 && wdata[0];
      ex = 0;
      if (sp) m_run = 0;
      else if (st) begin m_run = 1; m_pre = 0; m_cnt = m_reload; m_exp = m_cfg_exp; end
      else if (m_run != 0) begin
        if (m_pre == (1 << m_exp) - 1) begin
          m_pre = 0;
          if (m_cnt <= 1) begin
            ex = 1;
            if (m_auto != 0) m_cnt = m_reload;
            else begin m_cnt = 0; m_run = 0; end
          end else m_cnt--;
        end else m_pre++;
      end
      if (ex) m_irq = 1; else if (cl) m_irq = 0;
      if (we && addr == 0) begin m_cfg_exp = wdata[3:0]; m_auto = wdata[7]; end
      if (we && addr == 1) m_reload = wdata;
      if (we && addr == 2) m_trg = wdata[3:0];
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk({phase, " model count"}, count, m_cnt);
    chk({phase, " model running"}, running, m_run);
    chk({phase, " model irq"}, irq, m_irq);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(bit b0, bit b1, bit b2, bit b3);
    txb = b0; txe = b1; rxb = b2; rxe = b3;
    @(negedge clk);
    txb = 0; txe = 0; rxb = 0; rxe = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 count", count, 0); chk("R1 running", running, 0); chk("R1 irq", irq, 0);

    phase = "R2";
    wr(0, 8'h02); wr(1, 8'd3); wr(3, 8'h02);
    chk("R3 load", count, 3);
    step(3); chk("R2 no early tick", count, 3);
    step(1); chk("R2 tick at 4", count, 2);
    phase = "R3";
    step(7); chk("R3 before expiry", running, 1);
    step(1); chk("R4 halted", running, 0); chk("R4 count zero", count, 0); chk("R3 irq", irq, 1);
    phase = "R10";
    step(3); chk("R10 sticky", irq, 1);
    wr(3, 8'h01); chk("R10 cleared", irq, 0);

    phase = "R3";
    wr(0, 8'h00); wr(1, 8'd0); wr(3, 8'h02);
    step(1); chk("R3 zero reload expires", irq, 1); chk("R3 zero reload halts", running, 0);

    phase = "R4";
    wr(0, 8'h81); wr(1, 8'd2); wr(3, 8'h01); wr(3, 8'h02);
    step(4); chk("R4 auto running", running, 1); chk("R4 auto reload", count, 2);
    chk("R4 auto irq", irq, 1);
    phase = "R10";
    step(3); wr(3, 8'h01); chk("R10 set wins", irq, 1);
    wr(3, 8'h01); chk("R10 clear", irq, 0);
    phase = "R9";
    wr(1, 8'd5); chk("R9 count kept", count, 1);
    step(6);
    phase = "R5";
    wr(3, 8'h04); chk("R5 stopped", running, 0);
    step(5); chk("R5 count held", count, m_cnt);

    phase = "R6";
    wr(0, 8'h01); wr(1, 8'd20); wr(2, 8'h00);
    pulse(1, 1, 0, 0); chk("R6 disabled ignored", running, 0);
    wr(2, 8'h01);
    pulse(0, 1, 0, 0); chk("R6 tx end disabled", running, 0);
    pulse(1, 0, 0, 0); chk("R6 tx begin start", running, 1);
    phase = "R7";
    pulse(0, 0, 1, 1); chk("R7 disabled stop ignored", running, 1);
    wr(2, 8'h06);
    pulse(0, 0, 1, 0); chk("R7 rx begin stop", running, 0);
    phase = "R6";
    pulse(0, 1, 0, 0); chk("R6 tx end start", running, 1); chk("R6 load", count, 20);
    phase = "R7";
    wr(2, 8'h0A); step(3);
    pulse(0, 0, 0, 1); chk("R7 rx end stop", running, 0);

    phase = "R8";
    wr(2, 8'h05);
    pulse(1, 0, 1, 0); chk("R8 trigger stop wins", running, 0);
    wr(3, 8'h06); chk("R8 command stop wins", running, 0);
    wr(2, 8'h00);

    phase = "R11";
    wr(1, 8'd9); wr(3, 8'h02); step(5);
    wr(1, 8'd7); wr(3, 8'h02); chk("R11 restart load", count, 7);
    step(1); chk("R11 prescaler restarted", count, 7);
    step(1); chk("R11 first tick", count, 6);
    wr(3, 8'h04);

    phase = "R2";
    wr(0, 8'h07); wr(1, 8'd2); wr(3, 8'h01); wr(3, 8'h02);
    step(255); chk("R2 n7 before", running, 1); chk("R2 n7 count", count, 1);
    step(1); chk("R2 n7 expiry", running, 0); chk("R2 n7 irq", irq, 1);
    wr(0, 8'h0F); wr(1, 8'd1); wr(3, 8'h01); wr(3, 8'h02);
    step(32767); chk("R2 n15 before", running, 1);
    step(1); chk("R2 n15 expiry", running, 0); chk("R2 n15 irq", irq, 1);

    finish_run();
  end
endmodule